// File: doc/BRIEF.md
# Serial Command Register Interface for a Two-Frequency Four-Phase Synthesizer

This block is the configuration front end of a direct digital synthesizer. A host writes 16-bit command words over a serial link with chip select, a clock and a data line. The block samples the link in its own clock domain, puts each complete word together, decodes it, and updates the tuning and control registers that the synthesizer core reads. Two 32-bit frequency words, four 12-bit phase words, and a small set of select and power control bits come out on the ports.

Tuning registers are wider than the 8-bit data field of a word, so they are loaded in two steps. A buffer command first parks one byte in a holding register. A commit command then writes that byte and its own data byte into one 16-bit half of the target register in a single cycle. The synthesizer therefore only ever sees whole 16-bit halves change. A full 32-bit frequency update is four words: buffer and commit for the upper half, then the same for the lower half. Frames of the wrong length are dropped whole.

Top module: `dds_cmd_if`

## Requirements
- R1: A frame is the bits on `spi_mosi` sampled at rising edges of `spi_sclk` while `spi_cs_n` is low, MSB first. It takes effect when `spi_cs_n` rises after exactly 16 such edges. Word bits 15:12 are the command, 11:8 the address and 7:0 the data.
- R2: A frame with any count of clock edges other than 16 (including zero) changes no register.
- R3: Reset clears every frequency word, phase word, select bit, sync and source flag to 0, and sets sleep, core reset and clear to 1.
- R4: Command 0x2 at address a in 0x0..0x7 writes {frequency buffer, data} into bits [16*a[1] +: 16] of frequency word a[2]. The other half keeps its value.
- R5: Command 0x3 stores its data in the frequency buffer and changes no output. A frequency word changes only on a command 0x2 frame.
- R6: Command 0x1 stores its data in the phase buffer. Command 0x0 at address a in 0x8..0xF writes {phase buffer[3:0], data} into 12-bit phase word a[2:1]. Phase words change only on such a frame.
- R7: A frequency commit (0x2) at address 0x8..0xF and a phase commit (0x0) at address 0x0..0x7 are ignored.
- R8: Command 0x6 loads the frequency select from word bit 11 and the phase select from word bits 10:9.
- R9: Commands 0x8 to 0xB load the sync flag from word bit 13 and the source-select flag from word bit 12.
- R10: Commands 0xC to 0xF load sleep from word bit 13, core reset from bit 12 and clear from bit 11.
- R11: Commands 0x4, 0x5 and 0x7 change no register.
- R12: Frequency and phase buffers are separate. A commit uses the last byte buffered by the buffer command of its own kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are oversampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select that frames each word |
| spi_mosi | input | 1 | Serial data from the host |
| freq_words_o | output | 64 | Frequency word i at bits [32*i +: 32] |
| phase_words_o | output | 48 | Phase word i at bits [12*i +: 12] |
| freq_sel_o | output | 1 | Selected frequency word |
| phase_sel_o | output | 2 | Selected phase word |
| sync_o | output | 1 | Sync flag |
| src_sel_o | output | 1 | Source-select flag |
| sleep_o | output | 1 | Sleep control |
| core_rst_o | output | 1 | Synthesizer core reset control |
| clear_o | output | 1 | Clear control |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This lengthens the path from a serial edge to the register update and shows that the frame logic does not depend on a fixed latency. The register widths and counts stay at their defaults, so every address in 0x0..0xF maps to a real half-word or phase slot. This lets the out-of-range commits, the 15- and 17-edge frames and the separate buffers all be reached through the serial port alone.

// File: rtl/ddsc_pkg.sv
package ddsc_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FBUF,
    OP_FCMT,
    OP_PBUF,
    OP_PCMT,
    OP_SEL,
    OP_SYNC,
    OP_PWR
  } op_e;

  typedef struct packed {
    logic [3:0] cmd;
    logic [3:0] addr;
    logic [7:0] data;
  } frame_t;
endpackage

// File: rtl/ddsc_rst_sync.sv
module ddsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/ddsc_spi_rx.sv
module ddsc_spi_rx
  import ddsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_i,
  input  logic   cs_n_i,
  input  logic   mosi_i,
  output logic   word_vld_o,
  output frame_t word_o
);
  logic [SYNC_STAGES-1:0] sclk_sq, sclk_sd;
  logic [SYNC_STAGES-1:0] cs_sq, cs_sd;
  logic [SYNC_STAGES-1:0] mosi_sq, mosi_sd;
  logic                   sclk_s, cs_s, mosi_s;
  logic                   sclk_prev_q, cs_prev_q;
  logic                   sclk_rise, cs_rise;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [FRAME_BITS-1:0]  sh_q, sh_d;
  logic                   sh_en;
  logic                   vld_q, vld_d;

  assign sclk_s = sclk_sq[SYNC_STAGES-1];
  assign cs_s   = cs_sq[SYNC_STAGES-1];
  assign mosi_s = mosi_sq[SYNC_STAGES-1];

  always_comb begin
    sclk_sd   = {sclk_sq[SYNC_STAGES-2:0], sclk_i};
    cs_sd     = {cs_sq[SYNC_STAGES-2:0], cs_n_i};
    mosi_sd   = {mosi_sq[SYNC_STAGES-2:0], mosi_i};
    sclk_rise = sclk_s & ~sclk_prev_q;
    cs_rise   = cs_s & ~cs_prev_q;
    sh_en     = ~cs_s & sclk_rise;
    sh_d      = {sh_q[FRAME_BITS-2:0], mosi_s};
    cnt_d     = cnt_q;
    if (cs_s)
      cnt_d = '0;
    else if (sclk_rise && (cnt_q != CNT_W'(FRAME_BITS + 1)))
      cnt_d = cnt_q + 1'b1;
    vld_d = cs_rise && (cnt_q == CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sq     <= '0;
      cs_sq       <= '1;
      mosi_sq     <= '0;
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
      cnt_q       <= '0;
      vld_q       <= 1'b0;
    end else begin
      sclk_sq     <= sclk_sd;
      cs_sq       <= cs_sd;
      mosi_sq     <= mosi_sd;
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_s;
      cnt_q       <= cnt_d;
      vld_q       <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign word_vld_o = vld_q;
  assign word_o     = frame_t'(sh_q);

  // R2
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt_q == '0));

  // R1
  word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $stable(sh_q));
endmodule

// File: rtl/ddsc_decode.sv
module ddsc_decode
  import ddsc_pkg::*;
(
  input  logic       vld_i,
  input  frame_t     frm_i,
  output op_e        op_o,
  output logic [4:0] ctl_o,
  output logic [7:0] data_o
);
  logic unused_addr_lsb;

  assign unused_addr_lsb = frm_i.addr[0];
  assign ctl_o  = {frm_i.cmd[1:0], frm_i.addr[3:1]};
  assign data_o = frm_i.data;

  always_comb begin
    op_o = OP_NONE;
    if (vld_i) begin
      unique casez (frm_i.cmd)
        4'h3:    op_o = OP_FBUF;
        4'h2:    op_o = frm_i.addr[3] ? OP_NONE : OP_FCMT;
        4'h1:    op_o = OP_PBUF;
        4'h0:    op_o = frm_i.addr[3] ? OP_PCMT : OP_NONE;
        4'h6:    op_o = OP_SEL;
        4'b10??: op_o = OP_SYNC;
        4'b11??: op_o = OP_PWR;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ddsc_regfile.sv
module ddsc_regfile
  import ddsc_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int PHASE_W   = 12,
  parameter int NUM_FREQ  = 2,
  parameter int NUM_PHASE = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  op_e                                  op_i,
  input  logic [4:0]                           ctl_i,
  input  logic [7:0]                           data_i,
  output logic [NUM_FREQ-1:0][FREQ_W-1:0]      freq_o,
  output logic [NUM_PHASE-1:0][PHASE_W-1:0]    phase_o,
  output logic                                 fsel_o,
  output logic [1:0]                           psel_o,
  output logic                                 sync_o,
  output logic                                 src_o,
  output logic [2:0]                           pwr_o
);
  localparam int PHI_W = PHASE_W - 8;

  logic [7:0] fbuf_q, pbuf_q;
  logic       fbuf_en, pbuf_en;
  logic [NUM_FREQ-1:0][FREQ_W-1:0]   freq_q;
  logic [NUM_PHASE-1:0][PHASE_W-1:0] phase_q;
  logic       sel_en, sync_en, pwr_en;
  logic       fsel_q;
  logic [1:0] psel_q;
  logic       sync_q, src_q;
  logic [2:0] pwr_q;

  always_comb begin
    fbuf_en = (op_i == OP_FBUF);
    pbuf_en = (op_i == OP_PBUF);
    sel_en  = (op_i == OP_SEL);
    sync_en = (op_i == OP_SYNC);
    pwr_en  = (op_i == OP_PWR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbuf_q <= '0;
      pbuf_q <= '0;
    end else begin
      if (fbuf_en) fbuf_q <= data_i;
      if (pbuf_en) pbuf_q <= data_i;
    end
  end

  for (genvar gi = 0; gi < NUM_FREQ; gi++) begin : g_freq
    logic              wr;
    logic [FREQ_W-1:0] nxt;
    always_comb begin
      wr  = (op_i == OP_FCMT) && (int'(ctl_i[1]) == gi);
      nxt = freq_q[gi];
      nxt[int'(ctl_i[0])*16 +: 16] = {fbuf_q, data_i};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  freq_q[gi] <= '0;
      else if (wr) freq_q[gi] <= nxt;
    end
  end

  for (genvar gp = 0; gp < NUM_PHASE; gp++) begin : g_phase
    logic               wr;
    logic [PHASE_W-1:0] nxt;
    always_comb begin
      wr  = (op_i == OP_PCMT) && (int'(ctl_i[1:0]) == gp);
      nxt = {pbuf_q[PHI_W-1:0], data_i};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  phase_q[gp] <= '0;
      else if (wr) phase_q[gp] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= 1'b0;
      psel_q <= 2'b00;
      sync_q <= 1'b0;
      src_q  <= 1'b0;
      pwr_q  <= 3'b111;
    end else begin
      if (sel_en) begin
        fsel_q <= ctl_i[2];
        psel_q <= ctl_i[1:0];
      end
      if (sync_en) begin
        sync_q <= ctl_i[4];
        src_q  <= ctl_i[3];
      end
      if (pwr_en) pwr_q <= ctl_i[4:2];
    end
  end

  assign freq_o  = freq_q;
  assign phase_o = phase_q;
  assign fsel_o  = fsel_q;
  assign psel_o  = psel_q;
  assign sync_o  = sync_q;
  assign src_o   = src_q;
  assign pwr_o   = pwr_q;

  // R5
  tune_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_FCMT) |=> $stable(freq_q));

  // R4
  other_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FCMT && ctl_i[0] == 1'b0) |=>
      (freq_q[$past(ctl_i[1])][FREQ_W-1:16] == $past(freq_q[ctl_i[1]][FREQ_W-1:16])));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_PCMT) |=> $stable(phase_q));

  // R10
  pwr_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_PWR) |=> (pwr_q == $past(ctl_i[4:2])));

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE) |=> ($stable(pwr_q) && $stable(psel_q) && $stable(fsel_q)
                           && $stable(sync_q) && $stable(src_q)));
endmodule

// File: rtl/dds_cmd_if.sv
module dds_cmd_if
  import ddsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FREQ_W      = 32,
  parameter int PHASE_W     = 12,
  parameter int NUM_FREQ    = 2,
  parameter int NUM_PHASE   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           spi_sclk,
  input  logic                           spi_cs_n,
  input  logic                           spi_mosi,
  output logic [NUM_FREQ*FREQ_W-1:0]     freq_words_o,
  output logic [NUM_PHASE*PHASE_W-1:0]   phase_words_o,
  output logic                           freq_sel_o,
  output logic [1:0]                     phase_sel_o,
  output logic                           sync_o,
  output logic                           src_sel_o,
  output logic                           sleep_o,
  output logic                           core_rst_o,
  output logic                           clear_o
);
  logic       srst_n;
  logic       word_vld;
  frame_t     word;
  op_e        op;
  logic [4:0] ctl;
  logic [7:0] data;
  logic [2:0] pwr;
  logic [NUM_FREQ-1:0][FREQ_W-1:0]   freq;
  logic [NUM_PHASE-1:0][PHASE_W-1:0] phase;

  ddsc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (srst_n)
  );

  ddsc_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk        (clk),
    .rst_n      (srst_n),
    .sclk_i     (spi_sclk),
    .cs_n_i     (spi_cs_n),
    .mosi_i     (spi_mosi),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  ddsc_decode u_dec (
    .vld_i  (word_vld),
    .frm_i  (word),
    .op_o   (op),
    .ctl_o  (ctl),
    .data_o (data)
  );

  ddsc_regfile #(
    .FREQ_W    (FREQ_W),
    .PHASE_W   (PHASE_W),
    .NUM_FREQ  (NUM_FREQ),
    .NUM_PHASE (NUM_PHASE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .op_i    (op),
    .ctl_i   (ctl),
    .data_i  (data),
    .freq_o  (freq),
    .phase_o (phase),
    .fsel_o  (freq_sel_o),
    .psel_o  (phase_sel_o),
    .sync_o  (sync_o),
    .src_o   (src_sel_o),
    .pwr_o   (pwr)
  );

  assign freq_words_o  = freq;
  assign phase_words_o = phase;
  assign sleep_o       = pwr[2];
  assign core_rst_o    = pwr[1];
  assign clear_o       = pwr[0];
endmodule

// File: tb/sim_dds_cmd_if.sv
module sim_dds_cmd_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic [63:0] freq_words;
  logic [47:0] phase_words;
  logic        fsel, sync, src, sleep, crst, clr;
  logic [1:0]  psel;
  int          n_run = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  dds_cmd_if #(.SYNC_STAGES(3)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_sclk      (sclk),
    .spi_cs_n      (cs_n),
    .spi_mosi      (mosi),
    .freq_words_o  (freq_words),
    .phase_words_o (phase_words),
    .freq_sel_o    (fsel),
    .phase_sel_o   (psel),
    .sync_o        (sync),
    .src_sel_o     (src),
    .sleep_o       (sleep),
    .core_rst_o    (crst),
    .clear_o       (clr)
  );

  // Entry: {word, edge count, observed item, expected, requirement}
  // Observed item: 0/1 freq word, 2..5 phase word 0..3,
  // 6 control byte {fsel, psel[1:0], sync, src, sleep, core reset, clear}
  localparam int NV = 29;
  localparam logic [60:0] VEC [NV] = '{
    {16'h3312, 5'd16, 4'd0, 32'h0000_0000, 4'd5},   // R5 buffer alone
    {16'h2234, 5'd16, 4'd0, 32'h1234_0000, 4'd4},   // R4 upper half
    {16'h3156, 5'd16, 4'd0, 32'h1234_0000, 4'd5},
    {16'h2078, 5'd16, 4'd0, 32'h1234_5678, 4'd4},   // R4 lower half
    {16'h37AB, 5'd16, 4'd1, 32'h0000_0000, 4'd5},
    {16'h26CD, 5'd16, 4'd1, 32'hABCD_0000, 4'd4},
    {16'h35EF, 5'd16, 4'd1, 32'hABCD_0000, 4'd5},
    {16'h2411, 5'd15, 4'd1, 32'hABCD_0000, 4'd2},   // R2 short
    {16'h2411, 5'd17, 4'd1, 32'hABCD_0000, 4'd2},   // R2 long
    {16'h2411, 5'd16, 4'd1, 32'hABCD_EF11, 4'd1},   // R1
    {16'h19FA, 5'd16, 4'd2, 32'h0000_0000, 4'd6},
    {16'h08BC, 5'd16, 4'd2, 32'h0000_0ABC, 4'd6},   // R6 nibble kept
    {16'h1F05, 5'd16, 4'd5, 32'h0000_0000, 4'd6},
    {16'h0E67, 5'd16, 4'd5, 32'h0000_0567, 4'd6},
    {16'h0299, 5'd16, 4'd3, 32'h0000_0000, 4'd7},   // R7 phase low addr
    {16'h2944, 5'd16, 4'd0, 32'h1234_5678, 4'd7},   // R7 freq high addr
    {16'h31AA, 5'd16, 4'd0, 32'h1234_5678, 4'd12},  // R12
    {16'h1B0C, 5'd16, 4'd3, 32'h0000_0000, 4'd12},
    {16'h20BB, 5'd16, 4'd0, 32'h1234_AABB, 4'd12},
    {16'h0ADD, 5'd16, 4'd3, 32'h0000_0CDD, 4'd12},
    {16'h6E00, 5'd16, 4'd6, 32'h0000_00E7, 4'd8},   // R8
    {16'hB000, 5'd16, 4'd6, 32'h0000_00FF, 4'd9},   // R9
    {16'h9000, 5'd16, 4'd6, 32'h0000_00EF, 4'd9},
    {16'hC000, 5'd16, 4'd6, 32'h0000_00E8, 4'd10},  // R10
    {16'hD800, 5'd16, 4'd6, 32'h0000_00EB, 4'd10},
    {16'h4FFF, 5'd16, 4'd6, 32'h0000_00EB, 4'd11},  // R11
    {16'h5FFF, 5'd16, 4'd0, 32'h1234_AABB, 4'd11},
    {16'h7FFF, 5'd16, 4'd1, 32'hABCD_EF11, 4'd11},
    {16'h6000, 5'd8,  4'd6, 32'h0000_00EB, 4'd2}
  };

  function automatic logic [31:0] obs(input logic [3:0] s);
    case (s)
      4'd0:    return freq_words[31:0];
      4'd1:    return freq_words[63:32];
      4'd2:    return {20'd0, phase_words[11:0]};
      4'd3:    return {20'd0, phase_words[23:12]};
      4'd4:    return {20'd0, phase_words[35:24]};
      4'd5:    return {20'd0, phase_words[47:36]};
      4'd6:    return {24'd0, fsel, psel, sync, src, sleep, crst, clr};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [3:0] s, input logic [31:0] exp, input int req);
    logic [31:0] act;
    act = obs(s);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d item %0d: actual %h expected %h", req, s, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nb);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R3 reset state
    check(4'd0, 32'h0, 3);
    check(4'd1, 32'h0, 3);
    check(4'd2, 32'h0, 3);
    check(4'd5, 32'h0, 3);
    check(4'd6, 32'h07, 3);

    for (int k = 0; k < NV; k++) begin
      send(VEC[k][60:45], int'(VEC[k][44:40]));
      check(VEC[k][39:36], VEC[k][35:4], int'(VEC[k][3:0]));
    end

    // R2 chip select pulse with no clock edges
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (14) @(negedge clk);
    check(4'd6, 32'hEB, 2);
    check(4'd0, 32'h1234_AABB, 2);

    // R3 reset in mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(4'd0, 32'h0, 3);
    check(4'd1, 32'h0, 3);
    check(4'd3, 32'h0, 3);
    check(4'd6, 32'h07, 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule